// File: doc/BRIEF.md
# PCI-to-DRAM Host Snoop Sequencer

This block arbitrates the host processor bus on behalf of a PCI initiator that wants to reach system DRAM. When such a request arrives, it raises an address-hold output so the processor stops driving new addresses. It keeps that hold for the whole PCI burst. After the hold has been in place for a programmable number of cycles, it pulses a first-level-cache inquiry strobe. During that strobe it drives an invalidate qualifier that follows the direction of the PCI access.

The cycle after the strobe, the block samples the processor's hit-modified response. On a clean line it raises a proceed output to the PCI side at once. On a dirty line it stalls the PCI access until a writeback-done indication arrives. If a processor cycle is in flight at that moment, it also pulses back-off so that cycle is abandoned.

Peer-to-peer PCI traffic never takes the hold. A bus-grant hold input forces the hold on regardless of the sequence. A locked host sequence keeps PCI away from DRAM until the processor releases the lock.

Top module: `pci_snoop_seq`

## Requirements
- R1: During and after a synchronous active-low reset, addr_hold, inq_strobe, inv_out, back_off and pci_go are all 0 while no input is active.
- R2: A pci_req sampled high in the idle phase, with peer_xfer low and no lock in force, sets addr_hold the cycle after. addr_hold stays high through the burst. It drops the cycle after pci_done is sampled during the proceed phase.
- R3: inq_strobe is a single-cycle pulse. It is issued after addr_hold has been high for HOLD_LEAD cycles (default 1), so with the default it appears two cycles after the request is sampled.
- R4: During inq_strobe, inv_out equals 1 for a write snoop (pci_wr=1 at acceptance) and 0 for a read snoop (pci_wr=0). Outside the strobe it is 0.
- R5: A request sampled while peer_xfer is high is ignored: addr_hold and inq_strobe stay 0.
- R6: grant_hold high forces addr_hold high in the same cycle, whatever the sequence state.
- R7: hit_mod is sampled in the cycle after inq_strobe. If it is 0, pci_go is 1 from the next cycle on.
- R8: If hit_mod is 1 at that sample, pci_go stays 0 until wb_done is sampled high, and becomes 1 the cycle after.
- R9: back_off is a one-cycle pulse in the cycle after a hit_mod sample that sees host_busy=1. A hit with host_busy=0 gives no back_off.
- R10: Once host_lock and host_ads are sampled high together, no request is accepted until host_lock is sampled low. The first possible acceptance is at the clock edge after that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pci_req | input | 1 | PCI initiator requests a DRAM access (level) |
| pci_wr | input | 1 | Direction of the request: 1 write, 0 read |
| pci_done | input | 1 | PCI burst to DRAM has completed |
| peer_xfer | input | 1 | Current PCI transfer is peer-to-peer |
| grant_hold | input | 1 | Bus-grant hold from the bridge arbiter |
| host_lock | input | 1 | Processor lock, active high |
| host_ads | input | 1 | Processor address strobe, active high |
| host_busy | input | 1 | A processor cycle is in progress |
| hit_mod | input | 1 | Processor reports the snooped line as modified |
| wb_done | input | 1 | Writeback of the modified line has finished |
| addr_hold | output | 1 | Hold the processor address bus |
| inq_strobe | output | 1 | First-level-cache inquiry strobe |
| inv_out | output | 1 | Invalidate qualifier during the strobe |
| back_off | output | 1 | Force the processor to abandon its cycle |
| pci_go | output | 1 | PCI access may proceed to DRAM |

## Verification
Every result except the grant-hold override comes from a registered sequence state. Each of those results is due exactly one clock edge after the input that causes it is sampled. The path runs idle to hold to strobe to sample to proceed, with optional back-off and writeback phases in between. The bench drives inputs on the falling edge and checks on the falling edge after each rising edge. This lets it test the output of every phase in turn: the strobe two edges after the request, pci_go one edge after a clean sample or after wb_done. The lock release is two edges long, one to clear the lock and one to accept. The grant-hold override is combinational, so the bench checks it shortly after driving it in the same half cycle.

// File: rtl/snoop_pkg.sv
// Package: shared phase encoding for the snoop sequencer.
// Assumes: a single clock domain; the phases are listed in sequence order.
package snoop_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,    // no PCI access owned
        PH_HOLD,    // address bus held, waiting before the inquiry
        PH_INQ,     // inquiry strobe cycle
        PH_SAMPLE,  // hit-modified sampled here
        PH_BOFF,    // back-off pulse cycle
        PH_WB,      // waiting for the writeback to finish
        PH_GO       // PCI access proceeding, waiting for burst end
    } snoop_phase_t;
endpackage

// File: rtl/snoop_lock_track.sv
// Module: tracks locked host sequences.
// Does: latches a lock when host_lock and host_ads are sampled together and
//       clears it when host_lock is sampled low. Reports a block flag that
//       also covers the cycle in which the locked strobe is first seen.
// Assumes: host_lock stays asserted for the whole locked sequence.
module snoop_lock_track (
    input  logic clk,
    input  logic rst_n,
    input  logic host_lock,
    input  logic host_ads,
    output logic dram_blocked
);
    logic locked_q;

    // Holds the lock from the locked strobe until the lock is negated.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_q <= 1'b0;
        else if (host_lock && host_ads)
            locked_q <= 1'b1;
        else if (!host_lock)
            locked_q <= 1'b0;
    end

    // Blocks PCI acceptance while a lock is held or is being taken now.
    always_comb dram_blocked = locked_q || (host_lock && host_ads);

    assert_lock_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_lock |=> !locked_q);
endmodule

// File: rtl/snoop_ctrl_fsm.sv
// Module: sequence controller for one PCI-to-DRAM access.
// Does: accepts a request, holds the bus, issues the inquiry, samples the
//       hit-modified reply, optionally backs the processor off, waits for
//       the writeback, then lets the PCI side proceed until the burst ends.
// Assumes: pci_req stays high until pci_done; hit_mod is valid in the cycle
//          after the inquiry strobe.
module snoop_ctrl_fsm
    import snoop_pkg::*;
#(
    parameter int HOLD_LEAD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pci_req,
    input  logic pci_wr,
    input  logic pci_done,
    input  logic peer_xfer,
    input  logic dram_blocked,
    input  logic host_busy,
    input  logic hit_mod,
    input  logic wb_done,
    output logic seq_busy,
    output logic inq_strobe,
    output logic inv_out,
    output logic back_off,
    output logic pci_go
);
    localparam int CW = (HOLD_LEAD > 1) ? $clog2(HOLD_LEAD) : 1;
    localparam logic [CW-1:0] LEAD_LAST = CW'(HOLD_LEAD - 1);

    snoop_phase_t ph_q, ph_d;
    logic [CW-1:0] lead_q;
    logic          wr_q;

    // Picks the next phase from the current phase and the inputs.
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:   if (pci_req && !peer_xfer && !dram_blocked) ph_d = PH_HOLD;
            PH_HOLD:   if (lead_q == LEAD_LAST) ph_d = PH_INQ;
            PH_INQ:    ph_d = PH_SAMPLE;
            PH_SAMPLE: if (!hit_mod)       ph_d = PH_GO;
                       else if (host_busy) ph_d = PH_BOFF;
                       else                ph_d = PH_WB;
            PH_BOFF:   ph_d = PH_WB;
            PH_WB:     if (wb_done)  ph_d = PH_GO;
            PH_GO:     if (pci_done) ph_d = PH_IDLE;
            default:   ph_d = PH_IDLE;
        endcase
    end

    // Registers the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Counts hold cycles ahead of the inquiry and captures the direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q <= '0;
            wr_q   <= 1'b0;
        end else if (ph_q == PH_IDLE) begin
            lead_q <= '0;
            wr_q   <= pci_wr;
        end else if (ph_q == PH_HOLD) begin
            lead_q <= lead_q + 1'b1;
        end
    end

    // Decodes the Moore outputs from the phase.
    always_comb begin
        seq_busy   = (ph_q != PH_IDLE);
        inq_strobe = (ph_q == PH_INQ);
        inv_out    = (ph_q == PH_INQ) && wr_q;
        back_off   = (ph_q == PH_BOFF);
        pci_go     = (ph_q == PH_GO);
    end

    assert_accept_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> !$past(peer_xfer));
    assert_accept_unlocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> !$past(dram_blocked));
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inq_strobe |=> !inq_strobe);
    assert_inv_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inv_out |-> inq_strobe);
    assert_boff_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        back_off |-> ($past(hit_mod) && $past(host_busy)));
    assert_wb_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_WB && !wb_done) |=> !pci_go);
    assert_go_after_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_SAMPLE && !hit_mod) |=> pci_go);
endmodule

// File: rtl/pci_snoop_seq.sv
// Module: top of the PCI-to-DRAM host snoop sequencer.
// Does: joins the lock tracker and the sequence controller and merges the
//       bus-grant hold into the address-hold output.
// Assumes: all inputs are synchronous to clk.
module pci_snoop_seq #(
    parameter int HOLD_LEAD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pci_req,
    input  logic pci_wr,
    input  logic pci_done,
    input  logic peer_xfer,
    input  logic grant_hold,
    input  logic host_lock,
    input  logic host_ads,
    input  logic host_busy,
    input  logic hit_mod,
    input  logic wb_done,
    output logic addr_hold,
    output logic inq_strobe,
    output logic inv_out,
    output logic back_off,
    output logic pci_go
);
    logic dram_blocked;
    logic seq_busy;

    snoop_lock_track u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_lock    (host_lock),
        .host_ads     (host_ads),
        .dram_blocked (dram_blocked)
    );

    snoop_ctrl_fsm #(.HOLD_LEAD(HOLD_LEAD)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pci_req      (pci_req),
        .pci_wr       (pci_wr),
        .pci_done     (pci_done),
        .peer_xfer    (peer_xfer),
        .dram_blocked (dram_blocked),
        .host_busy    (host_busy),
        .hit_mod      (hit_mod),
        .wb_done      (wb_done),
        .seq_busy     (seq_busy),
        .inq_strobe   (inq_strobe),
        .inv_out      (inv_out),
        .back_off     (back_off),
        .pci_go       (pci_go)
    );

    // Holds the address bus for an owned access or while the grant hold is on.
    always_comb addr_hold = seq_busy || grant_hold;

    assert_strobe_after_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inq_strobe |-> $past(addr_hold));
    assert_grant_forces_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_hold |-> addr_hold);
    assert_go_under_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pci_go |-> addr_hold);
endmodule

// File: tb/sim_pci_snoop_seq.sv
module sim_pci_snoop_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pci_req = 0, pci_wr = 0, pci_done = 0, peer_xfer = 0, grant_hold = 0;
    logic host_lock = 0, host_ads = 0, host_busy = 0, hit_mod = 0, wb_done = 0;
    logic addr_hold, inq_strobe, inv_out, back_off, pci_go;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    pci_snoop_seq u0 (.*);

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drives a request and walks it to the sample phase, checking R2/R3/R4.
    task automatic start_access(logic wr);
        pci_req = 1; pci_wr = wr;
        tick();
        chk("R2 hold after accept", addr_hold, 1);
        chk("R3 no strobe yet", inq_strobe, 0);
        tick();
        chk("R3 strobe", inq_strobe, 1);
        chk("R4 inv polarity", inv_out, wr);
        tick();
        chk("R3 strobe single", inq_strobe, 0);
        chk("R4 inv low outside", inv_out, 0);
    endtask

    task automatic end_burst();
        tick();
        chk("R2 hold in burst", addr_hold, 1);
        pci_done = 1; pci_req = 0;
        tick();
        chk("R2 hold drop", addr_hold, 0);
        chk("R2 go drop", pci_go, 0);
        pci_done = 0;
    endtask

    task automatic t_reset();
        repeat (3) tick();
        chk("R1 hold", addr_hold, 0);
        chk("R1 strobe", inq_strobe, 0);
        chk("R1 inv", inv_out, 0);
        chk("R1 boff", back_off, 0);
        chk("R1 go", pci_go, 0);
        rst_n = 1;
        tick();
        chk("R1 hold idle", addr_hold, 0);
    endtask

    task automatic t_read_clean();
        start_access(0);
        tick();
        chk("R7 go after clean", pci_go, 1);
        chk("R9 no boff clean", back_off, 0);
        end_burst();
    endtask

    task automatic t_write_hit_busy();
        host_busy = 1;
        start_access(1);
        hit_mod = 1;
        tick();
        hit_mod = 0;
        chk("R9 boff pulse", back_off, 1);
        chk("R8 go held", pci_go, 0);
        tick();
        chk("R9 boff one cycle", back_off, 0);
        chk("R8 go held wb", pci_go, 0);
        tick();
        chk("R8 go still held", pci_go, 0);
        wb_done = 1;
        tick();
        wb_done = 0;
        chk("R8 go after wb", pci_go, 1);
        host_busy = 0;
        end_burst();
    endtask

    task automatic t_hit_idle_host();
        start_access(0);
        hit_mod = 1;
        tick();
        hit_mod = 0;
        chk("R9 no boff idle host", back_off, 0);
        chk("R8 go held", pci_go, 0);
        wb_done = 1;
        tick();
        wb_done = 0;
        chk("R8 go after wb", pci_go, 1);
        end_burst();
    endtask

    task automatic t_peer();
        peer_xfer = 1; pci_req = 1;
        tick();
        chk("R5 peer no hold", addr_hold, 0);
        tick();
        chk("R5 peer no strobe", inq_strobe, 0);
        chk("R5 peer still no hold", addr_hold, 0);
        peer_xfer = 0; pci_req = 0;
        tick();
    endtask

    task automatic t_grant();
        grant_hold = 1;
        #1;
        chk("R6 grant hold same cycle", addr_hold, 1);
        tick();
        chk("R6 grant hold held", addr_hold, 1);
        chk("R6 no strobe", inq_strobe, 0);
        grant_hold = 0;
        #1;
        chk("R6 release", addr_hold, 0);
        tick();
    endtask

    task automatic t_lock();
        host_lock = 1; host_ads = 1; pci_req = 1;
        tick();
        chk("R10 blocked at strobe", addr_hold, 0);
        host_ads = 0;
        tick();
        chk("R10 blocked in lock", addr_hold, 0);
        tick();
        host_lock = 0;
        tick();
        chk("R10 lock clearing", addr_hold, 0);
        tick();
        chk("R10 accepted after release", addr_hold, 1);
        tick();
        chk("R10 strobe after release", inq_strobe, 1);
        tick();
        tick();
        chk("R7 go", pci_go, 1);
        end_burst();
    endtask

    initial begin
        t_reset();
        t_read_clean();
        t_write_hit_busy();
        t_hit_idle_host();
        t_peer();
        t_grant();
        t_lock();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule